// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port synchronous memory. Two ports, left and right, each run from their own clock and reach one shared array of words whose width is a whole number of bytes (16 bits by default). The array depth is set by the address width parameter, with 8 bits by default and up to 16 bits for a 64K-word array. Every input a port receives is captured in a register on the rising edge of that port's clock. This covers the address, write data, byte-lane enables, the read/write direction, the output enable, the chip enables and the counter controls. The registered request is then carried out in the following cycle.

The address register of each port is also a burst counter. At each edge it can be cleared to zero, loaded from the address pins, stepped by one or left unchanged. A host can therefore give one start address and stream consecutive words after it, or load a new address on every cycle for random access. A port is selected only by a pair of chip enables of opposite polarity. Active-low byte-lane enables qualify each byte for both writes and reads. A per-port mode input picks the read latency: flow-through, or pipelined with one extra output register. The read port marks its data with a valid flag, which stands in for a driven bus. When no data is presented, the flag is low and the data reads as zero.

Both ports may touch the same word in the same cycle. If both write it, the left port wins on every lane it enables. A read that meets a write from the other port returns the contents from before that write.

Top module: `dpr_burst_ram`

## Requirements
- R1: A port acts only when its active-low enable is 0 and its active-high enable is 1. With any other pair it writes nothing and its valid flag stays 0.
- R2: A port whose active-low address strobe is 0 at an edge (and whose counter clear is 1) uses the address on its pins for that access.
- R3: Counter priority at each edge is clear (active low, sets address 0), then load, then step by one (active-low count enable), then hold when all three are 1.
- R4: Stepping from the top address (all ones) wraps to address 0.
- R5: On a write, the lane vector is active low, with bit 1 controlling data bits 15:8 and bit 0 controlling bits 7:0. A disabled lane keeps its old contents.
- R6: On a read, a disabled lane returns 0 while the valid flag stays 1.
- R7: In flow-through mode (mode input 0), a read whose inputs are captured at edge n presents data and valid after edge n+1.
- R8: In pipelined mode (mode input 1), the same read presents after edge n+2, and the flag is still 0 after edge n+1.
- R9: The valid flag is 1 only for a selected read with the active-low output enable at 0. Whenever the flag is 0, data is 0.
- R10: When both ports write one address in the same cycle, each lane enabled by the left port takes left data. Lanes that only the right port enables take right data.
- R11: A read on one port that meets a write to the same address by the other port in the same cycle returns the old word. The next read returns the new word.
- R12: Each port can write, and the other port can read, every address of the array.
- R13: Synchronous active-low reset clears a port's address register to 0 and its valid flag and data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port synchronous reset, active low |
| l_en_n | input | 1 | Left enable, active low |
| l_en | input | 1 | Left enable, active high |
| l_ld_n | input | 1 | Left address load strobe, active low |
| l_inc_n | input | 1 | Left counter step enable, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_addr | input | ADDR_W | Left address |
| l_wr_n | input | 1 | Left direction: 0 write, 1 read |
| l_lane_n | input | DATA_W/8 | Left byte-lane enables, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port synchronous reset, active low |
| r_en_n | input | 1 | Right enable, active low |
| r_en | input | 1 | Right enable, active high |
| r_ld_n | input | 1 | Right address load strobe, active low |
| r_inc_n | input | 1 | Right counter step enable, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_addr | input | ADDR_W | Right address |
| r_wr_n | input | 1 | Right direction: 0 write, 1 read |
| r_lane_n | input | DATA_W/8 | Right byte-lane enables, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The assertions check the address counter on every cycle. They cover the clear, load, step and hold priority, including the wrap from all ones. They also check that the read stage never shows non-zero data while its valid flag is low. Only the bench scenarios can show the rest. These are the byte-lane effects on stored words, the exact latency in each mode, the left-wins rule when both ports write, the old-data result of a read that meets a write, and that every address is reachable from both sides. The bench shows these by comparing read results against a shadow array it computes itself.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic {
      RD_FLOW = 1'b0,
      RD_PIPE = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/dpr_addr_ctr.sv
module dpr_addr_ctr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              ld_n,
   input  logic              inc_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)        addr_q <= '0;
      else if (!clr_n)   addr_q <= '0;
      else if (!ld_n)    addr_q <= addr_in;
      else if (!inc_n)   addr_q <= addr_q + ONE;
   end

   AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> addr_q == '0); // R3
   AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !ld_n) |=> addr_q == $past(addr_in)); // R2
   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && ld_n && !inc_n) |=> addr_q == ADDR_W'($past(addr_q) + ONE)); // R4
   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && ld_n && inc_n) |=> $stable(addr_q)); // R3
endmodule

// File: rtl/dpr_port_front.sv
module dpr_port_front #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / dpr_pkg::BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              en,
   input  logic              ld_n,
   input  logic              inc_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [LANES-1:0]  acc_we,
   output logic [DATA_W-1:0] acc_wdata,
   output logic              acc_rd,
   output logic [LANES-1:0]  acc_lanes
);
   logic             sel_q;
   logic             wr_q;
   logic             oe_q;
   logic [LANES-1:0] lane_q;

   dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_n   (clr_n),
      .ld_n    (ld_n),
      .inc_n   (inc_n),
      .addr_in (addr),
      .addr_q  (acc_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         wr_q      <= 1'b0;
         oe_q      <= 1'b0;
         lane_q    <= '0;
         acc_wdata <= '0;
      end else begin
         sel_q     <= !en_n && en;
         wr_q      <= !wr_n;
         oe_q      <= !oe_n;
         lane_q    <= ~lane_n;
         acc_wdata <= wdata;
      end
   end

   assign acc_we    = (sel_q && wr_q) ? lane_q : '0;
   assign acc_rd    = sel_q && !wr_q && oe_q;
   assign acc_lanes = lane_q;
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int LANES  = DATA_W / dpr_pkg::BYTE_W
) (
   input  logic              l_clk,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [LANES-1:0]  l_we,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_word,
   input  logic              r_clk,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [LANES-1:0]  r_we,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_word
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int BW    = dpr_pkg::BYTE_W;

   logic [DATA_W-1:0] mem_l [DEPTH];
   logic [DATA_W-1:0] mem_r [DEPTH];
   logic [LANES-1:0]  tag_l [DEPTH];
   logic [LANES-1:0]  tag_r [DEPTH];
   logic [LANES-1:0]  r_we_eff;

   // a right-side lane yields to a left-side write of the same word
   assign r_we_eff = (r_addr == l_addr) ? (r_we & ~l_we) : r_we;

   always_ff @(posedge l_clk) begin
      for (int b = 0; b < LANES; b++) begin
         if (l_we[b]) begin
            mem_l[l_addr][b*BW +: BW] <= l_wdata[b*BW +: BW];
            tag_l[l_addr][b]          <= ~tag_r[l_addr][b];
         end
      end
   end

   always_ff @(posedge r_clk) begin
      for (int b = 0; b < LANES; b++) begin
         if (r_we_eff[b]) begin
            mem_r[r_addr][b*BW +: BW] <= r_wdata[b*BW +: BW];
            tag_r[r_addr][b]          <= tag_l[r_addr][b];
         end
      end
   end

   // tags differ: left copy is newest; tags equal: right copy is newest
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign l_word[g*BW +: BW] = (tag_l[l_addr][g] != tag_r[l_addr][g]) ?
                                  mem_l[l_addr][g*BW +: BW] : mem_r[l_addr][g*BW +: BW];
      assign r_word[g*BW +: BW] = (tag_l[r_addr][g] != tag_r[r_addr][g]) ?
                                  mem_l[r_addr][g*BW +: BW] : mem_r[r_addr][g*BW +: BW];
   end
endmodule

// File: rtl/dpr_rd_stage.sv
module dpr_rd_stage #(
   parameter int  DATA_W   = 16,
   parameter int  LANES    = DATA_W / dpr_pkg::BYTE_W,
   parameter bit  HAS_PIPE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  logic [LANES-1:0]   lanes,
   input  logic [DATA_W-1:0]  word,
   input  dpr_pkg::rd_mode_e  mode,
   output logic [DATA_W-1:0]  rdata,
   output logic               rvalid
);
   localparam int BW = dpr_pkg::BYTE_W;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] d1_q;
   logic              v1_q;

   for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign mask[g*BW +: BW] = {BW{lanes[g]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         d1_q <= '0;
      end else begin
         v1_q <= rd;
         d1_q <= rd ? (word & mask) : '0;
      end
   end

   if (HAS_PIPE) begin : g_pipe
      logic [DATA_W-1:0] d2_q;
      logic              v2_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v2_q <= 1'b0;
            d2_q <= '0;
         end else begin
            v2_q <= v1_q;
            d2_q <= d1_q;
         end
      end
      assign rdata  = (mode == dpr_pkg::RD_PIPE) ? d2_q : d1_q;
      assign rvalid = (mode == dpr_pkg::RD_PIPE) ? v2_q : v1_q;
   end else begin : g_flow
      logic unused_mode;
      assign unused_mode = mode;
      assign rdata  = d1_q;
      assign rvalid = v1_q;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == '0); // R9
endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter bit HAS_PIPE = 1'b1,
   localparam int LANES   = DATA_W / dpr_pkg::BYTE_W
) (
   input  logic              l_clk,
   input  logic              l_rst_n,
   input  logic              l_en_n,
   input  logic              l_en,
   input  logic              l_ld_n,
   input  logic              l_inc_n,
   input  logic              l_clr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_wr_n,
   input  logic [LANES-1:0]  l_lane_n,
   input  logic              l_oe_n,
   input  logic              l_pipe,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   input  logic              r_clk,
   input  logic              r_rst_n,
   input  logic              r_en_n,
   input  logic              r_en,
   input  logic              r_ld_n,
   input  logic              r_inc_n,
   input  logic              r_clr_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_wr_n,
   input  logic [LANES-1:0]  r_lane_n,
   input  logic              r_oe_n,
   input  logic              r_pipe,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid
);
   if (DATA_W % dpr_pkg::BYTE_W != 0 || DATA_W < dpr_pkg::BYTE_W) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of the byte width");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 1..16");
   end

   logic [ADDR_W-1:0] la, ra;
   logic [LANES-1:0]  lwe, rwe, llanes, rlanes;
   logic [DATA_W-1:0] lwd, rwd, lword, rword;
   logic              lrd, rrd;

   dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_lfront (
      .clk(l_clk), .rst_n(l_rst_n), .en_n(l_en_n), .en(l_en), .ld_n(l_ld_n),
      .inc_n(l_inc_n), .clr_n(l_clr_n), .addr(l_addr), .wr_n(l_wr_n),
      .lane_n(l_lane_n), .oe_n(l_oe_n), .wdata(l_wdata),
      .acc_addr(la), .acc_we(lwe), .acc_wdata(lwd), .acc_rd(lrd), .acc_lanes(llanes)
   );

   dpr_port_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_rfront (
      .clk(r_clk), .rst_n(r_rst_n), .en_n(r_en_n), .en(r_en), .ld_n(r_ld_n),
      .inc_n(r_inc_n), .clr_n(r_clr_n), .addr(r_addr), .wr_n(r_wr_n),
      .lane_n(r_lane_n), .oe_n(r_oe_n), .wdata(r_wdata),
      .acc_addr(ra), .acc_we(rwe), .acc_wdata(rwd), .acc_rd(rrd), .acc_lanes(rlanes)
   );

   dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
      .l_clk(l_clk), .l_addr(la), .l_we(lwe), .l_wdata(lwd), .l_word(lword),
      .r_clk(r_clk), .r_addr(ra), .r_we(rwe), .r_wdata(rwd), .r_word(rword)
   );

   dpr_rd_stage #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(HAS_PIPE)) u_lrd (
      .clk(l_clk), .rst_n(l_rst_n), .rd(lrd), .lanes(llanes), .word(lword),
      .mode(dpr_pkg::rd_mode_e'(l_pipe)), .rdata(l_rdata), .rvalid(l_rvalid)
   );

   dpr_rd_stage #(.DATA_W(DATA_W), .LANES(LANES), .HAS_PIPE(HAS_PIPE)) u_rrd (
      .clk(r_clk), .rst_n(r_rst_n), .rd(rrd), .lanes(rlanes), .word(rword),
      .mode(dpr_pkg::rd_mode_e'(r_pipe)), .rdata(r_rdata), .rvalid(r_rvalid)
   );
endmodule

// File: tb/sim_dpr_burst_ram.sv
module sim_dpr_burst_ram;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n;
   always #2.5 clk = ~clk;

   logic          l_en_n, l_en, l_ld_n, l_inc_n, l_clr_n, l_wr_n, l_oe_n, l_pipe;
   logic [AW-1:0] l_addr;
   logic [1:0]    l_lane_n;
   logic [DW-1:0] l_wdata, l_rdata;
   logic          l_rvalid;
   logic          r_en_n, r_en, r_ld_n, r_inc_n, r_clr_n, r_wr_n, r_oe_n, r_pipe;
   logic [AW-1:0] r_addr;
   logic [1:0]    r_lane_n;
   logic [DW-1:0] r_wdata, r_rdata;
   logic          r_rvalid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [DW-1:0] shadow [DEPTH];

   dpr_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .l_clk(clk), .l_rst_n(rst_n), .l_en_n(l_en_n), .l_en(l_en), .l_ld_n(l_ld_n),
      .l_inc_n(l_inc_n), .l_clr_n(l_clr_n), .l_addr(l_addr), .l_wr_n(l_wr_n),
      .l_lane_n(l_lane_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe), .l_wdata(l_wdata),
      .l_rdata(l_rdata), .l_rvalid(l_rvalid),
      .r_clk(clk), .r_rst_n(rst_n), .r_en_n(r_en_n), .r_en(r_en), .r_ld_n(r_ld_n),
      .r_inc_n(r_inc_n), .r_clr_n(r_clr_n), .r_addr(r_addr), .r_wr_n(r_wr_n),
      .r_lane_n(r_lane_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe), .r_wdata(r_wdata),
      .r_rdata(r_rdata), .r_rvalid(r_rvalid)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return DW'((a * 16'h0103) ^ (a * 37) ^ salt);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_l();
      l_en_n = 1; l_en = 0; l_ld_n = 1; l_inc_n = 1; l_clr_n = 1;
      l_wr_n = 1; l_lane_n = 2'b00; l_oe_n = 0; l_addr = '0; l_wdata = '0;
   endtask

   task automatic idle_r();
      r_en_n = 1; r_en = 0; r_ld_n = 1; r_inc_n = 1; r_clr_n = 1;
      r_wr_n = 1; r_lane_n = 2'b00; r_oe_n = 0; r_addr = '0; r_wdata = '0;
   endtask

   // one right-port read (flow mode), checked after edge n+1
   task automatic r_acc(input logic clr_n, input logic ld_n, input logic inc_n,
                        input int a, input logic [1:0] lane_n, input logic en_n,
                        input logic en, input logic oe_n, input logic [DW-1:0] exp_d,
                        input logic exp_v, input string req);
      r_clr_n = clr_n; r_ld_n = ld_n; r_inc_n = inc_n; r_addr = AW'(a);
      r_lane_n = lane_n; r_en_n = en_n; r_en = en; r_oe_n = oe_n; r_wr_n = 1;
      tick();
      idle_r();
      tick();
      chk({req, " data"}, 32'(r_rdata), 32'(exp_d));
      chk({req, " valid"}, 32'(r_rvalid), 32'(exp_v));
   endtask

   task automatic r_rd(input int a, input logic [1:0] lane_n, input logic [DW-1:0] exp_d,
                       input string req);
      r_acc(1, 0, 1, a, lane_n, 0, 1, 0, exp_d, 1'b1, req);
   endtask

   task automatic l_wr(input int a, input logic [1:0] lane_n, input logic [DW-1:0] d,
                       input logic en_n, input logic en);
      l_ld_n = 0; l_addr = AW'(a); l_lane_n = lane_n; l_wdata = d;
      l_en_n = en_n; l_en = en; l_wr_n = 0;
      tick();
      idle_l();
      tick();
   endtask

   initial begin
      rst_n = 0; l_pipe = 0; r_pipe = 0;
      idle_l(); idle_r();
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R13: reset state
      chk("R13 l_rvalid", 32'(l_rvalid), 0);
      chk("R13 l_rdata", 32'(l_rdata), 0);
      chk("R13 r_rvalid", 32'(r_rvalid), 0);
      chk("R13 r_rdata", 32'(r_rdata), 0);

      // R12/R2/R3: left burst fill of the whole array
      for (int i = 0; i < DEPTH; i++) begin
         l_en_n = 0; l_en = 1; l_wr_n = 0; l_lane_n = 2'b00;
         l_wdata = pat(i, 16'h5A3C); shadow[i] = pat(i, 16'h5A3C);
         if (i == 0) begin l_ld_n = 0; l_addr = '0; end
         else begin l_ld_n = 1; l_inc_n = 0; end
         tick();
      end
      idle_l();
      tick();

      // R13: right address register is 0 after reset; a hold read hits word 0
      r_acc(1, 1, 1, 77, 2'b00, 0, 1, 0, shadow[0], 1'b1, "R13 reset address");

      // R7/R4/R12: right flow-through burst over all addresses plus wrap
      for (int j = 0; j <= DEPTH + 3; j++) begin
         if (j >= 2 && j - 2 <= DEPTH) begin
            chk((j - 2 == DEPTH) ? "R4 wrap data" : "R7 R12 burst data",
                32'(r_rdata), 32'(shadow[(j - 2) % DEPTH]));
            chk("R7 burst valid", 32'(r_rvalid), 1);
         end
         if (j - 2 == DEPTH + 1) begin
            chk("R9 after burst valid", 32'(r_rvalid), 0);
            chk("R9 after burst data", 32'(r_rdata), 0);
         end
         if (j <= DEPTH) begin
            r_en_n = 0; r_en = 1; r_wr_n = 1; r_oe_n = 0;
            if (j == 0) begin r_ld_n = 0; r_addr = '0; end
            else begin r_ld_n = 1; r_inc_n = 0; end
         end else idle_r();
         tick();
      end

      // R8: left pipelined burst
      l_pipe = 1;
      for (int j = 0; j <= DEPTH + 3; j++) begin
         if (j >= 3 && j - 3 < DEPTH) begin
            chk("R8 pipe burst data", 32'(l_rdata), 32'(shadow[j - 3]));
            chk("R8 pipe burst valid", 32'(l_rvalid), 1);
         end
         if (j < DEPTH) begin
            l_en_n = 0; l_en = 1; l_wr_n = 1; l_oe_n = 0;
            if (j == 0) begin l_ld_n = 0; l_addr = '0; end
            else begin l_ld_n = 1; l_inc_n = 0; end
         end else idle_l();
         tick();
      end
      // R8: single read is absent after edge n+1, present after n+2
      l_en_n = 0; l_en = 1; l_wr_n = 1; l_ld_n = 0; l_addr = 8'd20;
      tick();
      idle_l();
      tick();
      chk("R8 early valid", 32'(l_rvalid), 0);
      tick();
      chk("R8 late data", 32'(l_rdata), 32'(shadow[20]));
      chk("R8 late valid", 32'(l_rvalid), 1);
      l_pipe = 0;
      tick();

      // R5: lane writes (bit1 = 15:8, bit0 = 7:0, active low)
      l_wr(5, 2'b10, 16'hFFFF, 0, 1);
      shadow[5] = {shadow[5][15:8], 8'hFF};
      r_rd(5, 2'b00, shadow[5], "R5 lower lane write");
      l_wr(5, 2'b01, 16'h1234, 0, 1);
      shadow[5] = {8'h12, shadow[5][7:0]};
      r_rd(5, 2'b00, shadow[5], "R5 upper lane write");

      // R6: lane-qualified reads
      r_rd(5, 2'b01, shadow[5] & 16'hFF00, "R6 upper only read");
      r_rd(5, 2'b10, shadow[5] & 16'h00FF, "R6 lower only read");
      r_rd(5, 2'b11, 16'h0000, "R6 no lane read");

      // R1: deselected writes have no effect; deselected read gives no valid
      l_wr(7, 2'b00, 16'hDEAD, 1, 1);
      l_wr(7, 2'b00, 16'hDEAD, 0, 0);
      l_wr(7, 2'b00, 16'hDEAD, 1, 0);
      r_rd(7, 2'b00, shadow[7], "R1 deselected write");
      r_acc(1, 0, 1, 7, 2'b00, 0, 0, 0, 16'h0, 1'b0, "R1 deselected read");
      r_acc(1, 0, 1, 7, 2'b00, 1, 1, 0, 16'h0, 1'b0, "R1 deselected read b");

      // R9: output enable high gives no valid and zero data
      r_acc(1, 0, 1, 7, 2'b00, 0, 1, 1, 16'h0, 1'b0, "R9 oe high");

      // R10: simultaneous writes to one address
      l_en_n = 0; l_en = 1; l_wr_n = 0; l_ld_n = 0; l_addr = 9; l_lane_n = 2'b00; l_wdata = 16'h1111;
      r_en_n = 0; r_en = 1; r_wr_n = 0; r_ld_n = 0; r_addr = 9; r_lane_n = 2'b00; r_wdata = 16'h2222;
      tick(); idle_l(); idle_r(); tick();
      r_rd(9, 2'b00, 16'h1111, "R10 full collision");
      l_en_n = 0; l_en = 1; l_wr_n = 0; l_ld_n = 0; l_addr = 9; l_lane_n = 2'b10; l_wdata = 16'h00AA;
      r_en_n = 0; r_en = 1; r_wr_n = 0; r_ld_n = 0; r_addr = 9; r_lane_n = 2'b00; r_wdata = 16'hBBCC;
      tick(); idle_l(); idle_r(); tick();
      r_rd(9, 2'b00, 16'hBBAA, "R10 partial collision");

      // R11: read meets other-port write
      l_en_n = 0; l_en = 1; l_wr_n = 0; l_ld_n = 0; l_addr = 11; l_lane_n = 2'b00; l_wdata = 16'h7777;
      r_en_n = 0; r_en = 1; r_wr_n = 1; r_ld_n = 0; r_addr = 11; r_lane_n = 2'b00;
      tick(); idle_l(); idle_r(); tick();
      chk("R11 old data right", 32'(r_rdata), 32'(shadow[11]));
      shadow[11] = 16'h7777;
      r_rd(11, 2'b00, 16'h7777, "R11 new data right");
      r_en_n = 0; r_en = 1; r_wr_n = 0; r_ld_n = 0; r_addr = 12; r_lane_n = 2'b00; r_wdata = 16'h3C3C;
      l_en_n = 0; l_en = 1; l_wr_n = 1; l_ld_n = 0; l_addr = 12; l_lane_n = 2'b00;
      tick(); idle_l(); idle_r(); tick();
      chk("R11 old data left", 32'(l_rdata), 32'(shadow[12]));
      shadow[12] = 16'h3C3C;
      r_rd(12, 2'b00, 16'h3C3C, "R11 new data left");

      // R3: counter priority
      r_acc(0, 0, 0, 33, 2'b00, 0, 1, 0, shadow[0], 1'b1, "R3 clear wins");
      r_acc(1, 0, 0, 40, 2'b00, 0, 1, 0, shadow[40], 1'b1, "R3 load over step");
      r_acc(1, 1, 0, 90, 2'b00, 0, 1, 0, shadow[41], 1'b1, "R3 step");
      r_acc(1, 1, 1, 90, 2'b00, 0, 1, 0, shadow[41], 1'b1, "R3 hold");

      // R12: right writes, left reads
      for (int i = 0; i < DEPTH; i += 17) begin
         r_en_n = 0; r_en = 1; r_wr_n = 0; r_ld_n = 0; r_addr = AW'(i);
         r_wdata = pat(i, 16'h0F0F); shadow[i] = pat(i, 16'h0F0F);
         tick(); idle_r(); tick();
         l_en_n = 0; l_en = 1; l_wr_n = 1; l_ld_n = 0; l_addr = AW'(i);
         tick(); idle_l(); tick();
         chk("R12 right write left read", 32'(l_rdata), 32'(shadow[i]));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog got=hung exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule